// File: doc/BRIEF.md
# PWM Sync Pulse Generator

This block sits beside a PWM counter and turns its cycle strobes into a synchronization pulse of programmable length. A strobe at the start of a PWM period always launches a pulse. A strobe at the period midpoint launches a pulse only when the double-refresh mode bit is set. The pulse length comes from a width operand: a value of W gives a pulse of W+1 clock cycles. A new strobe that arrives while a pulse is still high reloads the length counter, so two pulses never merge into one of unpredictable length.

The block can also take its timing from outside. An external sync pin, which may be fully asynchronous to the core clock, passes through a two-flop synchronizer. It is then qualified by a minimum-width filter: the synchronized level must stay high for three consecutive core cycles. A qualified pulse produces exactly one single-cycle restart request to the PWM counter, but only while the source select input chooses the external source. The locally generated sync pulse keeps following the counter strobes in either source mode.

Top module: `pwm_sync_gen`

## Requirements
- R1: While reset is held and right after it, `sync_pulse_o` and `restart_o` are 0.
- R2: A `period_start_i` strobe sampled at clock edge e drives `sync_pulse_o` high from edge e+1 for exactly `pulse_width_i`+1 cycles (a width of 0 gives 1 cycle).
- R3: When `dbl_update_i` is 1, a `midpoint_i` strobe launches a pulse with the same timing and length as R2.
- R4: When `dbl_update_i` is 0, a `midpoint_i` strobe has no effect on `sync_pulse_o`.
- R5: A strobe sampled while a pulse is high reloads the length, so the pulse ends `pulse_width_i`+1 cycles after the last strobe.
- R6: With `ext_sel_i` = 1, an `ext_sync_i` high level sampled at three consecutive edges e0..e2 produces `restart_o` high for exactly one cycle, right after edge e0+4.
- R7: An `ext_sync_i` high level sampled at no more than two consecutive edges produces no `restart_o`.
- R8: An `ext_sync_i` high level held for many cycles produces exactly one `restart_o` pulse.
- R9: With `ext_sel_i` = 0, `ext_sync_i` activity produces no `restart_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_start_i | input | 1 | Single-cycle strobe at the start of each PWM period |
| midpoint_i | input | 1 | Single-cycle strobe at the midpoint of each PWM period |
| dbl_update_i | input | 1 | 1 = double-refresh mode, midpoint strobe also launches a pulse |
| pulse_width_i | input | PW_W | Pulse length minus one, in core cycles |
| ext_sel_i | input | 1 | 1 = external sync pin drives restart requests |
| ext_sync_i | input | 1 | External sync pin, asynchronous |
| sync_pulse_o | output | 1 | Locally generated sync pulse |
| restart_o | output | 1 | Single-cycle request to restart the PWM period |

## Verification
A strobe sampled at edge e shows on `sync_pulse_o` one register later, so the bench drives strobes on the falling edge, lets one rising edge pass and then counts high samples on each later falling edge until the pulse drops, which must equal the width plus one. The external path has two synchronizer flops, two more cycles of width qualification and an output register, so `restart_o` is due right after the fifth rising edge that sees the pin high. The bench counts falling edges from the one on which it raises the pin and expects the request on exactly the fifth. The rejection and single-request cases count requests over a window long enough to cover that latency after the pin falls.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  // Default width of the pulse length operand.
  localparam int unsigned PW_W_DEF        = 8;
  // Default number of synchronizer flops on the external pin.
  localparam int unsigned SYNC_STAGES_DEF = 2;
  // Default number of consecutive synchronized high cycles to accept a pulse.
  localparam int unsigned MIN_HI_DEF      = 3;

  // Source of restart requests.
  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_PIN   = 1'b1
  } sync_src_e;
endpackage

// File: rtl/pwm_sync_rst.sv
module pwm_sync_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = rs_q[STAGES-1];
endmodule

// File: rtl/pwm_sync_width.sv
module pwm_sync_width #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic [PW_W-1:0] width_i,
  output logic            pulse_o
);
  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            act_q, act_d;
  logic            cnt_en;

  // Counter only moves on a trigger or while a pulse is live.
  assign cnt_en = trig_i | act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (trig_i) begin
      cnt_d = width_i;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign pulse_o = act_q;
endmodule

// File: rtl/pwm_sync_ext.sv
module pwm_sync_ext #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_HI      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  output logic restart_o
);
  localparam int unsigned CNT_W = $clog2(MIN_HI + 1);
  localparam logic [CNT_W-1:0] HI_MAX  = CNT_W'(MIN_HI);
  localparam logic [CNT_W-1:0] HI_FIRE = CNT_W'(MIN_HI - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level;
  logic [CNT_W-1:0]       hi_q, hi_d;
  logic                   req_q, req_d;

  // Synchronizer chain, one flop per stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign level = sync_q[SYNC_STAGES-1];

  // Run-length of the synchronized high level, saturating at MIN_HI; the
  // request fires once, on the cycle the run reaches MIN_HI.
  always_comb begin
    if (!level)              hi_d = '0;
    else if (hi_q == HI_MAX) hi_d = hi_q;
    else                     hi_d = hi_q + 1'b1;
    req_d = level & (hi_q == HI_FIRE) & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      req_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      req_q <= req_d;
    end
  end

  assign restart_o = req_q;
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
  import pwm_sync_pkg::*;
#(
  parameter int unsigned PW_W        = PW_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned MIN_HI      = MIN_HI_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_start_i,
  input  logic            midpoint_i,
  input  logic            dbl_update_i,
  input  logic [PW_W-1:0] pulse_width_i,
  input  logic            ext_sel_i,
  input  logic            ext_sync_i,
  output logic            sync_pulse_o,
  output logic            restart_o
);
  logic      rst_core_n;
  logic      trig;
  sync_src_e src;

  pwm_sync_rst #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign trig = period_start_i | (dbl_update_i & midpoint_i);
  assign src  = sync_src_e'(ext_sel_i);

  pwm_sync_width #(.PW_W(PW_W)) i_width (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .trig_i  (trig),
    .width_i (pulse_width_i),
    .pulse_o (sync_pulse_o)
  );

  pwm_sync_ext #(.SYNC_STAGES(SYNC_STAGES), .MIN_HI(MIN_HI)) i_ext (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pin_i     (ext_sync_i),
    .en_i      (src == SRC_PIN),
    .restart_o (restart_o)
  );
endmodule

// File: rtl/pwm_sync_gen_chk.sv
module pwm_sync_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic period_start_i,
  input logic midpoint_i,
  input logic dbl_update_i,
  input logic ext_sel_i,
  input logic sync_pulse_o,
  input logic restart_o
);
  // R2 / R3: a launching strobe is followed by a high pulse.
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start_i || (dbl_update_i && midpoint_i)) |=> sync_pulse_o);

  // R4: no strobe that counts means no new pulse from idle.
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pulse_o && !period_start_i && !(dbl_update_i && midpoint_i))
      |=> !sync_pulse_o);

  // R6: a restart request lasts exactly one cycle.
  p_restart_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  // R9: local source selected means no restart request.
  p_no_restart_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel_i |=> !restart_o);

  // R1: outputs low while reset is asserted.
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!sync_pulse_o && !restart_o);
    end
  end
endmodule

bind pwm_sync_gen pwm_sync_gen_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .period_start_i (period_start_i),
  .midpoint_i     (midpoint_i),
  .dbl_update_i   (dbl_update_i),
  .ext_sel_i      (ext_sel_i),
  .sync_pulse_o   (sync_pulse_o),
  .restart_o      (restart_o)
);

// File: tb/test_pwm_sync_gen.sv
module test_pwm_sync_gen;
  localparam int PW_W = 8;

  logic            clk;
  logic            rst_n;
  logic            period_start_i;
  logic            midpoint_i;
  logic            dbl_update_i;
  logic [PW_W-1:0] pulse_width_i;
  logic            ext_sel_i;
  logic            ext_sync_i;
  logic            sync_pulse_o;
  logic            restart_o;

  int n_checks;
  int n_fail;
  bit done;

  pwm_sync_gen #(.PW_W(PW_W)) i_pwm_sync_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .period_start_i (period_start_i),
    .midpoint_i     (midpoint_i),
    .dbl_update_i   (dbl_update_i),
    .pulse_width_i  (pulse_width_i),
    .ext_sel_i      (ext_sel_i),
    .ext_sync_i     (ext_sync_i),
    .sync_pulse_o   (sync_pulse_o),
    .restart_o      (restart_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe sampled at the next rising edge, then count high samples.
  task automatic pulse_len(input bit ps, input bit mp, output int n);
    @(negedge clk);
    period_start_i = ps;
    midpoint_i     = mp;
    @(negedge clk);
    period_start_i = 1'b0;
    midpoint_i     = 1'b0;
    n = 0;
    while (sync_pulse_o && n < 600) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    period_start_i = 0; midpoint_i = 0; dbl_update_i = 0;
    pulse_width_i = 0; ext_sel_i = 0; ext_sync_i = 0;
    repeat (3) @(negedge clk);
    check("R1 sync_pulse_o in reset", int'(sync_pulse_o), 0);
    check("R1 restart_o in reset", int'(restart_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sync_pulse_o after reset", int'(sync_pulse_o), 0);
    check("R1 restart_o after reset", int'(restart_o), 0);
  endtask

  task automatic t_period_width();
    int n;
    dbl_update_i = 0;
    pulse_width_i = 8'd5;
    pulse_len(1, 0, n);
    check("R2 width 5", n, 6);
    pulse_width_i = 8'd0;
    pulse_len(1, 0, n);
    check("R2 width 0", n, 1);
    pulse_width_i = 8'd200;
    pulse_len(1, 0, n);
    check("R2 width 200", n, 201);
  endtask

  task automatic t_midpoint();
    int n;
    pulse_width_i = 8'd3;
    dbl_update_i = 1;
    pulse_len(0, 1, n);
    check("R3 midpoint in double mode", n, 4);
    dbl_update_i = 0;
    pulse_len(0, 1, n);
    check("R4 midpoint in single mode", n, 0);
    repeat (3) @(negedge clk);
    check("R4 output stays low", int'(sync_pulse_o), 0);
  endtask

  task automatic t_retrigger();
    int n;
    pulse_width_i = 8'd4;
    @(negedge clk);
    period_start_i = 1;
    @(negedge clk);
    period_start_i = 0;
    repeat (2) @(negedge clk);   // pulse high for 3 samples so far
    period_start_i = 1;
    @(negedge clk);
    period_start_i = 0;
    n = 0;
    while (sync_pulse_o && n < 600) begin
      n++;
      @(negedge clk);
    end
    check("R5 pulse after reload", n, 5);
  endtask

  // Raise the pin, drop it at negedge index drop_at, record restarts.
  task automatic ext_run(input int drop_at, input int span, output int cnt, output int first);
    cnt = 0;
    first = -1;
    @(negedge clk);
    ext_sync_i = 1;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (restart_o) begin
        cnt++;
        if (first < 0) first = i;
      end
      if (i == drop_at) ext_sync_i = 0;
    end
  endtask

  task automatic t_ext_accept();
    int cnt, first;
    ext_sel_i = 1;
    ext_run(3, 12, cnt, first);
    check("R6 restart count", cnt, 1);
    check("R6 restart cycle", first, 5);
  endtask

  task automatic t_ext_short();
    int cnt, first;
    ext_sel_i = 1;
    ext_run(2, 12, cnt, first);
    check("R7 two-cycle pulse rejected", cnt, 0);
  endtask

  task automatic t_ext_long();
    int cnt, first;
    ext_sel_i = 1;
    ext_run(40, 50, cnt, first);
    check("R8 long pulse one restart", cnt, 1);
  endtask

  task automatic t_ext_local();
    int cnt, first;
    ext_sel_i = 0;
    ext_run(10, 20, cnt, first);
    check("R9 local source no restart", cnt, 0);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 0;
    t_reset();
    t_period_width();
    t_midpoint();
    t_retrigger();
    t_ext_accept();
    t_ext_short();
    t_ext_long();
    t_ext_local();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule